// File: doc/BRIEF.md
# Stack Push Wrap Fault Checker

This block sits beside the stack logic of a 16-bit-offset machine and judges each push before its memory write is issued. A request carries the operand size (two or four bytes) and the current stack pointer. The block works out the decremented pointer, then checks whether the bytes written from that pointer upward would run past the last offset of the 64 KiB space. Because the decrement can wrap a small pointer round to the top of the space, the end of the access is computed one bit wider than the offset. A carry into that extra bit marks the push as a fault. It does not become a write that silently lands at a low offset.

A legal push produces, one clock after the request, a one-cycle `done` pulse. The pulse comes with the new pointer, the write address and the byte count. A push that would wrap produces a one-cycle `fault` pulse instead. On a fault the pointer, address and byte-count outputs keep the values of the last legal push, so the caller's stack pointer stays as it was. A request can be presented on every cycle.

Top module: `stk_push_guard`

## Requirements
- R1: While reset is held and right after it is released, `done` and `fault` are 0, and `sp_out`, `wr_addr` and `wr_bytes` are 0.
- R2: Each cycle with `req_valid`=1 is answered on the next cycle by exactly one of `done` or `fault`, for that one cycle only. No pulse appears on either output in a cycle that follows a cycle without a request.
- R3: A word push (`req_dword`=0, two bytes) that does not fault gives `sp_out` = `req_sp` − 2 modulo 65536 and `wr_bytes` = 2.
- R4: A dword push (`req_dword`=1, four bytes) that does not fault gives `sp_out` = `req_sp` − 4 modulo 65536 and `wr_bytes` = 4.
- R5: A word push with `req_sp` = 1 wraps to 0xFFFF, and its second byte would fall beyond offset 0xFFFF, so it raises `fault`.
- R6: A dword push with `req_sp` equal to 1, 2 or 3 raises `fault`.
- R7: A push with `req_sp` = 0 is legal. A word push gives 0xFFFE and a dword push gives 0xFFFC, with `done` and no `fault`.
- R8: When `fault` is raised, `sp_out`, `wr_addr` and `wr_bytes` keep the values they had before the faulting request.
- R9: Whenever `done` is high, `wr_addr` equals `sp_out`.
- R10: A push whose pointer is at least the operand size never faults, including the case where the new pointer becomes exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Push request present this cycle |
| req_dword | input | 1 | Operand size: 0 = two bytes, 1 = four bytes |
| req_sp | input | 16 | Stack pointer before the push |
| done | output | 1 | One-cycle pulse: push is legal, write may proceed |
| fault | output | 1 | One-cycle pulse: push would run past the top offset |
| sp_out | output | 16 | Stack pointer after the last legal push |
| wr_addr | output | 16 | Lowest byte offset of the last legal write |
| wr_bytes | output | 3 | Byte count of the last legal write |

## Verification
The pointer values near the bottom of the space are swept for both sizes. The values 0, 1, 2, 3 and 4 separate the wrap that is still legal (0 lands exactly on the top offset), the wraps that must fault, and the exact-zero result that must not fault. Mid-range pointers show that the plain decrement and the byte count are right away from any boundary. Faults placed between legal pushes show that the held outputs are the ones from the last legal push and not from the rejected one. Back-to-back and gapped request streams, followed by a pseudo-random run over small and large pointers, separate a correct one-cycle latency from lost, doubled or spurious pulses.

// File: rtl/stk_pkg.sv
package stk_pkg;

    // Operand size code carried on req_dword
    typedef enum logic {
        PUSH_WORD  = 1'b0,
        PUSH_DWORD = 1'b1
    } push_size_e;

    // Width of the byte-count field (holds 2 or 4)
    localparam int unsigned BYTES_W = 3;

    localparam logic [BYTES_W-1:0] WORD_BYTES  = BYTES_W'(2);
    localparam logic [BYTES_W-1:0] DWORD_BYTES = BYTES_W'(4);

    function automatic logic [BYTES_W-1:0] size_to_bytes(input push_size_e sz);
        return (sz == PUSH_DWORD) ? DWORD_BYTES : WORD_BYTES;
    endfunction

endpackage

// File: rtl/stk_span_calc.sv
module stk_span_calc
    import stk_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]  sp_cur,
    input  push_size_e         size_sel,
    output logic [ADDR_W-1:0]  sp_next,
    output logic [BYTES_W-1:0] span_bytes,
    output logic               span_wraps
);

    // One extra bit so a carry past the top offset is kept
    localparam int unsigned SPAN_W = ADDR_W + 1;

    logic [BYTES_W-1:0] bytes_w;
    logic [ADDR_W-1:0]  dec_w;
    logic [SPAN_W-1:0]  last_byte_w;

    always_comb begin
        bytes_w     = size_to_bytes(size_sel);
        // Decrement wraps within the offset width
        dec_w       = sp_cur - ADDR_W'(bytes_w);
        // Offset of the highest byte written, computed without truncation
        last_byte_w = {1'b0, dec_w} + SPAN_W'(bytes_w) - SPAN_W'(1);
    end

    assign sp_next    = dec_w;
    assign span_bytes = bytes_w;
    assign span_wraps = last_byte_w[SPAN_W-1];

endmodule

// File: rtl/stk_resp_reg.sv
module stk_resp_reg
    import stk_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_dword,
    input  logic [ADDR_W-1:0]  req_sp,
    input  logic [ADDR_W-1:0]  calc_sp,
    input  logic [BYTES_W-1:0] calc_bytes,
    input  logic               calc_wraps,
    output logic               done,
    output logic               fault,
    output logic [ADDR_W-1:0]  sp_out,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [BYTES_W-1:0] wr_bytes
);

    typedef struct packed {
        logic               done;
        logic               fault;
        logic [ADDR_W-1:0]  sp;
        logic [ADDR_W-1:0]  addr;
        logic [BYTES_W-1:0] bytes;
    } resp_state_t;

    resp_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.fault = 1'b0;
        if (req_valid) begin
            if (calc_wraps) begin
                st_d.fault = 1'b1;
            end else begin
                st_d.done  = 1'b1;
                st_d.sp    = calc_sp;
                st_d.addr  = calc_sp;
                st_d.bytes = calc_bytes;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done     = st_q.done;
    assign fault    = st_q.fault;
    assign sp_out   = st_q.sp;
    assign wr_addr  = st_q.addr;
    assign wr_bytes = st_q.bytes;

    localparam logic [ADDR_W-1:0] TWO_W  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] FOUR_W = ADDR_W'(4);

    // R2
    resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (done || fault));

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!done && !fault));

    // R8
    hold_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(sp_out) && $stable(wr_addr) && $stable(wr_bytes)));

    // R5
    word_wrap_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dword && req_sp == ADDR_W'(1)) |=> fault);

    // R6
    dword_wrap_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dword && req_sp != '0 && req_sp < FOUR_W) |=> fault);

    // R3
    word_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dword && req_sp != ADDR_W'(1))
        |=> (done && sp_out == $past(req_sp) - TWO_W && wr_bytes == 3'd2));

    // R4
    dword_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dword && (req_sp == '0 || req_sp >= FOUR_W))
        |=> (done && sp_out == $past(req_sp) - FOUR_W && wr_bytes == 3'd4));

    // R9
    addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_addr == sp_out));

endmodule

// File: rtl/stk_push_guard.sv
module stk_push_guard
    import stk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_dword,
    input  logic [15:0] req_sp,
    output logic        done,
    output logic        fault,
    output logic [15:0] sp_out,
    output logic [15:0] wr_addr,
    output logic [2:0]  wr_bytes
);

    localparam int unsigned ADDR_W = 16;

    push_size_e         size_w;
    logic [ADDR_W-1:0]  calc_sp_w;
    logic [BYTES_W-1:0] calc_bytes_w;
    logic               calc_wraps_w;

    assign size_w = push_size_e'(req_dword);

    stk_span_calc #(
        .ADDR_W (ADDR_W)
    ) span_i (
        .sp_cur     (req_sp),
        .size_sel   (size_w),
        .sp_next    (calc_sp_w),
        .span_bytes (calc_bytes_w),
        .span_wraps (calc_wraps_w)
    );

    stk_resp_reg #(
        .ADDR_W (ADDR_W)
    ) resp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_dword  (req_dword),
        .req_sp     (req_sp),
        .calc_sp    (calc_sp_w),
        .calc_bytes (calc_bytes_w),
        .calc_wraps (calc_wraps_w),
        .done       (done),
        .fault      (fault),
        .sp_out     (sp_out),
        .wr_addr    (wr_addr),
        .wr_bytes   (wr_bytes)
    );

endmodule

// File: tb/stk_push_guard_tb_top.sv
`timescale 1ns/1ps
module stk_push_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_dword = 1'b0;
    logic [15:0] req_sp = '0;
    logic        done, fault;
    logic [15:0] sp_out, wr_addr;
    logic [2:0]  wr_bytes;

    always #2.5 clk = ~clk;

    stk_push_guard dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_dword (req_dword),
        .req_sp (req_sp), .done (done), .fault (fault), .sp_out (sp_out),
        .wr_addr (wr_addr), .wr_bytes (wr_bytes)
    );

    typedef struct {
        int          due;
        logic        flt;
        logic [15:0] sp;
        logic [2:0]  nb;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [15:0] m_sp = '0;
    logic [2:0]  m_nb = '0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Driver: applies a request and records its expected outcome
    task automatic push(input logic dw, input logic [15:0] sp, input string tag);
        exp_t e;
        int sz;
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_dword = dw;
        req_sp    = sp;
        sz = dw ? 4 : 2;
        e.due = cyc + 1;
        e.tag = tag;
        e.flt = (sp != 16'd0) && (int'(sp) < sz);
        if (!e.flt) begin
            m_sp = sp - 16'(sz);
            m_nb = 3'(sz);
        end
        e.sp = m_sp;
        e.nb = m_nb;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compares each response with the head of the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (done || fault) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected pulse", {done, fault}, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.due, "R2", "latency", cyc, e.due);
                    check(!(done && fault), "R2", "both pulses", {done, fault}, {~e.flt, e.flt});
                    check(fault == e.flt, e.tag, "fault", fault, e.flt);
                    check(sp_out == e.sp, e.flt ? "R8" : e.tag, "sp_out", sp_out, e.sp);
                    check(wr_bytes == e.nb, e.flt ? "R8" : e.tag, "wr_bytes", wr_bytes, e.nb);
                    check(wr_addr == e.sp, e.flt ? "R8" : "R9", "wr_addr", wr_addr, e.sp);
                end
            end else if (exp_q.size() != 0 && exp_q[0].due <= cyc) begin
                exp_t e;
                e = exp_q.pop_front();
                check(0, "R2", "missing response", 0, 1);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        check(!done && !fault, "R1", "pulses in reset", {done, fault}, 0);
        check(sp_out == 0 && wr_addr == 0 && wr_bytes == 0, "R1", "regs in reset",
              sp_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after release
        check(!done && !fault && sp_out == 0 && wr_bytes == 0, "R1", "after release",
              sp_out, 0);

        push(1'b0, 16'h1000, "R3");
        push(1'b1, 16'h1000, "R4");
        push(1'b0, 16'h0000, "R7");
        push(1'b1, 16'h0000, "R7");
        push(1'b0, 16'h0001, "R5");
        push(1'b1, 16'h0001, "R6");
        push(1'b1, 16'h0002, "R6");
        push(1'b1, 16'h0003, "R6");
        idle(2);
        push(1'b0, 16'h0002, "R10");
        push(1'b1, 16'h0004, "R10");
        push(1'b0, 16'h0003, "R10");
        push(1'b1, 16'hFFFF, "R4");
        push(1'b0, 16'h0001, "R5");
        idle(3);
        push(1'b0, 16'h8001, "R3");
        idle(1);
        push(1'b1, 16'h0002, "R6");
        idle(1);

        lfsr = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            logic [15:0] sp;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sp = lfsr[0] ? {13'd0, lfsr[3:1]} : lfsr;
            push(lfsr[4], sp, lfsr[4] ? "R4" : "R3");
            if (lfsr[5] && lfsr[6]) idle(1);
        end
        idle(4);
        check(exp_q.size() == 0, "R2", "responses outstanding", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule